// File: doc/BRIEF.md
# Triplicated Upset Classifier Harness

This harness runs three identical copies of a small combinational network (a parameterized adder) side by side. Each copy has its own input register and output register, and all three copies take the same stream of pseudo-random vectors from one 32-bit LFSR. The harness compares the three captured output words in pairs on every cycle. It registers the three comparison results as a 3-bit signature and sorts each nonzero signature into a class.

A one-hot signature means that a single comparison flop was upset. The copies themselves still agree, so the reported difference word is zero. A two-hot signature means that one copy's network produced a wrong word, which is a transient captured by that copy's output register. All three bits set is indeterminate. Each class has its own saturating counter. Every non-clean cycle raises a one-cycle event that carries the signature, the class, a cycle timestamp and a difference word.

For fault injection, a test environment can force a glitch on the network output node of any copy, or flip any comparison flop.

Top module: `upsetClassifier`

## Requirements
- R1: While reset is asserted and after it is released, evtValid is 0 and all three counters read 0.
- R2: A 32-bit maximal-length LFSR with a nonzero seed feeds the same vector to all three copies. With no injection, no event is raised.
- R3: Signature bit 0 compares copy 0 with copy 1, bit 1 compares copy 1 with copy 2, and bit 2 compares copy 0 with copy 2. A glitch on copy 0, 1 or 2 yields 101, 011 or 110 respectively.
- R4: The class code is 1 (upset) for a one-hot signature, 2 (transient) for a two-hot signature and 3 (indeterminate) for 111. Signature 000 raises no event.
- R5: A glitch sampled at clock edge E produces evtValid at edge E+2. A comparison-flop flip sampled at edge E produces evtValid at edge E+1. evtValid lasts one cycle.
- R6: evtDiff is the XOR of the two words of the lowest-numbered set signature bit. For an upset-only event it is 0.
- R7: evtStamp is a free-running cycle count taken at the comparison stage. Two events n cycles apart differ by n.
- R8: The upset, transient and indeterminate counters are each 16 bits wide. Each counts only its own class and saturates at 65535.
- R9: clrCnt synchronously zeroes all counters. It wins over an increment in the same cycle, and it does not suppress the event.
- R10: Signature 111 increments only the indeterminate counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| clrCnt | input | 1 | Synchronous clear of all class counters |
| glitchEn | input | 3 | Per-copy enable of a one-cycle glitch on the network output |
| glitchMask | input | 9 | Bits flipped by a glitch |
| upsetInj | input | 3 | Per-pair flip of the comparison flop |
| evtValid | output | 1 | One-cycle event strobe |
| evtSig | output | 3 | Event signature |
| evtClass | output | 2 | Event class code |
| evtStamp | output | 32 | Cycle timestamp of the comparison |
| evtDiff | output | 9 | Difference word of the lowest mismatching pair |
| upsetCnt | output | 16 | Saturating upset count |
| transCnt | output | 16 | Saturating transient count |
| indetCnt | output | 16 | Saturating indeterminate count |

## Verification
Two things can fall in the same cycle: a counter clear and a counted event, and a network glitch and a comparison-flop flip. The bench provokes the first by pulsing clrCnt at the edge that would count an event. It expects the event to appear on the outputs while the counters read zero. For the second, it times a glitch on copy 1 and a flip of the copy 0 / copy 2 comparison so that both land in one comparison cycle. The merged signature 111 must then be classed as indeterminate, must carry the glitch mask as its difference word, and must leave the other two counters unchanged.

// File: rtl/upsetPkg.sv
package upsetPkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_UPSET = 2'd1,
    CLS_TRANS = 2'd2,
    CLS_INDET = 2'd3
  } evtClass_e;

  typedef struct packed {
    logic      evtLoad;
    evtClass_e evtCls;
    logic      incUpset;
    logic      incTrans;
    logic      incIndet;
    logic      clrAll;
  } ctrlStrobe_t;

  localparam int NUM_COPIES = 3;
  localparam int NUM_PAIRS  = 3;

  // Pair p compares copy pairLeft(p) with copy pairRight(p)
  function automatic int pairLeft(input int p);
    return (p == 1) ? 1 : 0;
  endfunction

  function automatic int pairRight(input int p);
    return (p == 0) ? 1 : 2;
  endfunction

endpackage

// File: rtl/lfsrGen.sv
module lfsrGen #(
  parameter int          OUT_W = 16,
  parameter logic [31:0] SEED  = 32'h1D2C_3B4A
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [OUT_W-1:0] vecOut
);
  // Galois form of x^32 + x^22 + x^2 + x + 1
  localparam logic [31:0] TAP_MASK = 32'h8020_0003;

  logic [31:0] state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAP_MASK;
    else state <= state >> 1;
  end

  assign vecOut = state[OUT_W-1:0];

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    state != 32'd0); // R2
  AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> state != $past(state)); // R2
endmodule

// File: rtl/nutCopy.sv
module nutCopy #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2*OP_W-1:0] vecIn,
  input  logic            glitchEn,
  input  logic [OP_W:0]   glitchMask,
  output logic [OP_W:0]   outWord
);
  logic [2*OP_W-1:0] inReg;
  logic [OP_W:0]     netNode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inReg <= '0;
    else inReg <= vecIn;
  end

  // network under test: operand adder with a glitchable output node
  always_comb begin
    netNode = {1'b0, inReg[OP_W-1:0]} + {1'b0, inReg[2*OP_W-1:OP_W]};
    if (glitchEn) netNode = netNode ^ glitchMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outWord <= '0;
    else outWord <= netNode;
  end
endmodule

// File: rtl/classCtrl.sv
module classCtrl
  import upsetPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cmpSig,
  input  logic        clrCnt,
  output ctrlStrobe_t strb
);
  logic [1:0] hotCount;

  always_comb begin
    hotCount = 2'(cmpSig[0]) + 2'(cmpSig[1]) + 2'(cmpSig[2]);
    strb = '0;
    strb.clrAll  = clrCnt;
    strb.evtLoad = (hotCount != 2'd0);
    unique case (hotCount)
      2'd1: begin strb.evtCls = CLS_UPSET; strb.incUpset = 1'b1; end
      2'd2: begin strb.evtCls = CLS_TRANS; strb.incTrans = 1'b1; end
      2'd3: begin strb.evtCls = CLS_INDET; strb.incIndet = 1'b1; end
      default: strb.evtCls = CLS_NONE;
    endcase
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.incUpset, strb.incTrans, strb.incIndet})); // R4
  AST_CLEAN_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (cmpSig == 3'b000) |-> !strb.evtLoad); // R4
  AST_INDET_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cmpSig == 3'b111) |-> (strb.incIndet && !strb.incUpset && !strb.incTrans)); // R10
endmodule

// File: rtl/harnessDatapath.sv
module harnessDatapath
  import upsetPkg::*;
#(
  parameter int          OP_W  = 8,
  parameter int          CNT_W = 16,
  parameter int          TS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2*OP_W-1:0] vecIn,
  input  logic [2:0]        glitchEn,
  input  logic [OP_W:0]     glitchMask,
  input  logic [2:0]        upsetInj,
  input  ctrlStrobe_t       strb,
  output logic [2:0]        cmpSig,
  output logic              evtValid,
  output logic [2:0]        evtSig,
  output logic [1:0]        evtClass,
  output logic [TS_W-1:0]   evtStamp,
  output logic [OP_W:0]     evtDiff,
  output logic [CNT_W-1:0]  upsetCnt,
  output logic [CNT_W-1:0]  transCnt,
  output logic [CNT_W-1:0]  indetCnt
);
  localparam int OUT_W = OP_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [OUT_W-1:0] copyOut [NUM_COPIES];
  logic [OUT_W-1:0] pairXor [NUM_PAIRS];
  logic [2:0]       cmpBit;
  logic [OUT_W-1:0] selDiff;
  logic [TS_W-1:0]  cycCnt;
  logic [CNT_W-1:0] classCnt [3];
  logic [2:0]       incVec;

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
    nutCopy #(.OP_W(OP_W)) u_copy (
      .clk        (clk),
      .rstN       (rstN),
      .vecIn      (vecIn),
      .glitchEn   (glitchEn[k]),
      .glitchMask (glitchMask),
      .outWord    (copyOut[k])
    );
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int LA = pairLeft(p);
    localparam int RB = pairRight(p);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pairXor[p] <= '0;
        cmpBit[p]  <= 1'b0;
      end else begin
        pairXor[p] <= copyOut[LA] ^ copyOut[RB];
        cmpBit[p]  <= (copyOut[LA] != copyOut[RB]) ^ upsetInj[p];
      end
    end
  end

  assign cmpSig = cmpBit;

  // difference word of the lowest-numbered set signature bit
  always_comb begin
    selDiff = '0;
    for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
      if (cmpBit[p]) selDiff = pairXor[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycCnt <= '0;
    else cycCnt <= cycCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid <= 1'b0;
      evtSig   <= '0;
      evtClass <= CLS_NONE;
      evtStamp <= '0;
      evtDiff  <= '0;
    end else begin
      evtValid <= strb.evtLoad;
      if (strb.evtLoad) begin
        evtSig   <= cmpBit;
        evtClass <= strb.evtCls;
        evtStamp <= cycCnt;
        evtDiff  <= selDiff;
      end
    end
  end

  assign incVec = {strb.incIndet, strb.incTrans, strb.incUpset};

  for (genvar c = 0; c < 3; c++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) classCnt[c] <= '0;
      else if (strb.clrAll) classCnt[c] <= '0;
      else if (incVec[c] && classCnt[c] != CNT_MAX) classCnt[c] <= classCnt[c] + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      !strb.clrAll |=> (classCnt[c] == $past(classCnt[c]) ||
                        classCnt[c] == $past(classCnt[c]) + 1'b1)); // R8
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (classCnt[c] == CNT_MAX && !strb.clrAll) |=> classCnt[c] == CNT_MAX); // R8
  end

  assign upsetCnt = classCnt[0];
  assign transCnt = classCnt[1];
  assign indetCnt = classCnt[2];

  AST_EVT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> evtSig != 3'b000); // R4
  AST_UPSET_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && $countones(evtSig) == 1) |-> evtClass == CLS_UPSET); // R4
  AST_TRANS_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && $countones(evtSig) == 2) |-> evtClass == CLS_TRANS); // R4
  AST_EVT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (cmpSig != 3'b000) |=> (evtValid && evtSig == $past(cmpSig))); // R5
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (upsetCnt == '0 && transCnt == '0 && indetCnt == '0)); // R9
endmodule

// File: rtl/upsetClassifier.sv
module upsetClassifier
  import upsetPkg::*;
#(
  parameter int          OP_W  = 8,
  parameter int          CNT_W = 16,
  parameter int          TS_W  = 32,
  parameter logic [31:0] SEED  = 32'h1D2C_3B4A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrCnt,
  input  logic [2:0]        glitchEn,
  input  logic [OP_W:0]     glitchMask,
  input  logic [2:0]        upsetInj,
  output logic              evtValid,
  output logic [2:0]        evtSig,
  output logic [1:0]        evtClass,
  output logic [TS_W-1:0]   evtStamp,
  output logic [OP_W:0]     evtDiff,
  output logic [CNT_W-1:0]  upsetCnt,
  output logic [CNT_W-1:0]  transCnt,
  output logic [CNT_W-1:0]  indetCnt
);
  localparam int VEC_W = 2 * OP_W;

  logic [VEC_W-1:0] vecBus;
  logic [2:0]       cmpSig;
  ctrlStrobe_t      strb;

  lfsrGen #(.OUT_W(VEC_W), .SEED(SEED)) u_lfsr (
    .clk    (clk),
    .rstN   (rstN),
    .vecOut (vecBus)
  );

  classCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cmpSig (cmpSig),
    .clrCnt (clrCnt),
    .strb   (strb)
  );

  harnessDatapath #(.OP_W(OP_W), .CNT_W(CNT_W), .TS_W(TS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .vecIn      (vecBus),
    .glitchEn   (glitchEn),
    .glitchMask (glitchMask),
    .upsetInj   (upsetInj),
    .strb       (strb),
    .cmpSig     (cmpSig),
    .evtValid   (evtValid),
    .evtSig     (evtSig),
    .evtClass   (evtClass),
    .evtStamp   (evtStamp),
    .evtDiff    (evtDiff),
    .upsetCnt   (upsetCnt),
    .transCnt   (transCnt),
    .indetCnt   (indetCnt)
  );
endmodule

// File: tb/upsetClassifier_bench.sv
`timescale 1ns/1ps
module upsetClassifier_bench;
  logic        clk;
  logic        rstN;
  logic        clrCnt;
  logic [2:0]  glitchEn;
  logic [8:0]  glitchMask;
  logic [2:0]  upsetInj;
  logic        evtValid;
  logic [2:0]  evtSig;
  logic [1:0]  evtClass;
  logic [31:0] evtStamp;
  logic [8:0]  evtDiff;
  logic [15:0] upsetCnt;
  logic [15:0] transCnt;
  logic [15:0] indetCnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int expUp = 0;
  int expTr = 0;
  int expIn = 0;

  upsetClassifier u_upsetClassifier (
    .clk(clk), .rstN(rstN), .clrCnt(clrCnt), .glitchEn(glitchEn),
    .glitchMask(glitchMask), .upsetInj(upsetInj), .evtValid(evtValid),
    .evtSig(evtSig), .evtClass(evtClass), .evtStamp(evtStamp),
    .evtDiff(evtDiff), .upsetCnt(upsetCnt), .transCnt(transCnt),
    .indetCnt(indetCnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkCounts(input string req);
    chk({req, " upsetCnt"}, 64'(upsetCnt), 64'(expUp));
    chk({req, " transCnt"}, 64'(transCnt), 64'(expTr));
    chk({req, " indetCnt"}, 64'(indetCnt), 64'(expIn));
  endtask

  task automatic testReset();
    rstN = 1'b0; clrCnt = 1'b0; glitchEn = '0; glitchMask = '0; upsetInj = '0;
    negs(4);
    chk("R1 evtValid in reset", 64'(evtValid), 64'd0);
    chkCounts("R1 in reset");
    rstN = 1'b1;
    negs(2);
    chk("R1 evtValid after reset", 64'(evtValid), 64'd0);
    chkCounts("R1 after reset");
  endtask

  task automatic testQuiet();
    int seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (evtValid) seen++;
    end
    chk("R2 no event without injection", 64'(seen), 64'd0);
  endtask

  task automatic testGlitch(input int k, input logic [8:0] mask, input logic [2:0] expSig);
    glitchMask = mask;
    glitchEn = 3'(1 << k);
    @(negedge clk);
    glitchEn = '0;
    @(negedge clk);
    chk("R5 glitch not early", 64'(evtValid), 64'd0);
    @(negedge clk);
    expTr++;
    chk("R5 glitch event valid", 64'(evtValid), 64'd1);
    chk("R3 glitch signature", 64'(evtSig), 64'(expSig));
    chk("R4 transient class", 64'(evtClass), 64'd2);
    chk("R6 glitch diff", 64'(evtDiff), 64'(mask));
    chkCounts("R8 transient count");
    @(negedge clk);
    chk("R5 one-cycle pulse", 64'(evtValid), 64'd0);
  endtask

  task automatic testUpset(input int p);
    upsetInj = 3'(1 << p);
    @(negedge clk);
    upsetInj = '0;
    @(negedge clk);
    expUp++;
    chk("R5 upset event valid", 64'(evtValid), 64'd1);
    chk("R4 upset signature one-hot", 64'(evtSig), 64'(1 << p));
    chk("R4 upset class", 64'(evtClass), 64'd1);
    chk("R6 upset diff zero", 64'(evtDiff), 64'd0);
    chkCounts("R8 upset count");
    @(negedge clk);
    chk("R5 upset pulse ends", 64'(evtValid), 64'd0);
  endtask

  task automatic testIndet();
    glitchMask = 9'h0A5;
    glitchEn = 3'b010;
    @(negedge clk);
    glitchEn = '0;
    upsetInj = 3'b100;
    @(negedge clk);
    upsetInj = '0;
    @(negedge clk);
    expIn++;
    chk("R10 merged signature", 64'(evtSig), 64'd7);
    chk("R4 indeterminate class", 64'(evtClass), 64'd3);
    chk("R6 indeterminate diff", 64'(evtDiff), 64'h0A5);
    chkCounts("R10 only indeterminate counted");
  endtask

  task automatic testStamp();
    logic [31:0] s1;
    upsetInj = 3'b001;
    @(negedge clk);
    upsetInj = '0;
    @(negedge clk);
    s1 = evtStamp;
    negs(3);
    upsetInj = 3'b001;
    @(negedge clk);
    upsetInj = '0;
    @(negedge clk);
    expUp += 2;
    chk("R7 stamp spacing", 64'(evtStamp - s1), 64'd5);
    chkCounts("R7 counts");
  endtask

  task automatic testClearCoincide();
    upsetInj = 3'b001;
    @(negedge clk);
    upsetInj = '0;
    clrCnt = 1'b1;
    @(negedge clk);
    clrCnt = 1'b0;
    expUp = 0; expTr = 0; expIn = 0;
    chk("R9 event survives clear", 64'(evtValid), 64'd1);
    chk("R9 event class with clear", 64'(evtClass), 64'd1);
    chkCounts("R9 clear wins");
    @(negedge clk);
    chkCounts("R9 stays clear");
  endtask

  task automatic testSaturate();
    upsetInj = 3'b010;
    negs(65540);
    upsetInj = '0;
    negs(3);
    expUp = 65535;
    chkCounts("R8 saturation");
    clrCnt = 1'b1;
    @(negedge clk);
    clrCnt = 1'b0;
    @(negedge clk);
    expUp = 0;
    chkCounts("R9 clear after saturation");
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testQuiet();
    testGlitch(0, 9'h001, 3'b101);
    testGlitch(1, 9'h180, 3'b011);
    testGlitch(2, 9'h05A, 3'b110);
    testUpset(0);
    testUpset(1);
    testUpset(2);
    testIndet();
    testStamp();
    testClearCoincide();
    testQuiet();
    testSaturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule